// File: doc/BRIEF.md
# Sign-Classifying Condition Flag Register

This block keeps three status flags that describe a 32-bit two's-complement value as negative, zero or strictly positive. A separate one-bit load strobe decides when that description is taken: only a low-to-high transition of the strobe, sampled on the system clock, causes the operand to be classified and the flags to be rewritten. Between such transitions the flags hold, whatever the operand does.

The logic is built around two small state machines. The strobe tracker has two states. `SS_ARMED` means the strobe was last seen low. `SS_BLOCKED` means the strobe was last seen high, or reset has just ended. The tracker raises a one-cycle rise pulse on the transition from `SS_ARMED` to `SS_BLOCKED`, which happens when the strobe is sampled high. The return from `SS_BLOCKED` to `SS_ARMED` happens when the strobe is sampled low. The flag machine has four states: `FS_CLEAR` (the reset state), `FS_NEG`, `FS_ZERO` and `FS_POS`. On a rise pulse it moves from any state to the state named by the operand's class. Without a rise pulse it stays where it is. Synchronous reset forces `FS_CLEAR` and `SS_BLOCKED`. A combinational classifier sits between the operand and the flag machine.

Top module: `sign_flag_reg`

## Requirements
- R1: While `rst` is sampled high at a rising clock edge, all three flags read 0 after that edge, and they remain 0 until a rise of the strobe is accepted.
- R2: When a strobe rise is accepted with operand bit 31 equal to 1, the flags read N=1, Z=0, P=0 after that same clock edge.
- R3: When a strobe rise is accepted with all 32 operand bits equal to 0, the flags read N=0, Z=1, P=0 after that same clock edge.
- R4: When a strobe rise is accepted with bit 31 equal to 0 and any other bit equal to 1, the flags read N=0, Z=0, P=1 after that same clock edge. This includes the operands 0x00000001 and 0x7FFFFFFF.
- R5: Once any load has been accepted since reset, exactly one of N, Z and P is 1. No state ever has more than one flag set.
- R6: If a clock edge has no accepted strobe rise, the flags after that edge equal the flags before it, whatever value the operand has.
- R7: A strobe held high over several clock edges is accepted only at the first of them. A new load requires the strobe to be sampled low at least once and then sampled high again.
- R8: A strobe that is high on the first edge after reset is released is not a rise. It is only accepted after it has been sampled low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| operand | input | 32 | Two's-complement value to classify |
| load_stb | input | 1 | Load strobe; its sampled rising transition triggers a capture |
| flag_n | output | 1 | Operand was negative at the last capture |
| flag_z | output | 1 | Operand was zero at the last capture |
| flag_p | output | 1 | Operand was strictly positive at the last capture |

## Verification
Every result is due at the clock edge that samples the stimulus. An accepted rise rewrites the flags at the same edge that first samples the strobe high, with no extra pipeline stage, and a held or blocked strobe leaves them unchanged at that edge. The driver applies one stimulus per cycle on the falling edge and queues the flag triple expected after the next rising edge. The monitor takes one entry from the queue shortly after each rising edge and compares it, so each expectation is matched to exactly the cycle its requirement names.

// File: rtl/sign_flag_pkg.sv
package sign_flag_pkg;

    // Class of the operand as produced by the classifier.
    typedef enum logic [1:0] {
        CLS_NEG  = 2'd0,
        CLS_ZERO = 2'd1,
        CLS_POS  = 2'd2
    } op_class_e;

    // Strobe tracker states.
    typedef enum logic {
        SS_ARMED   = 1'b0,
        SS_BLOCKED = 1'b1
    } stb_state_e;

    // Flag machine states.
    typedef enum logic [1:0] {
        FS_CLEAR = 2'd0,
        FS_NEG   = 2'd1,
        FS_ZERO  = 2'd2,
        FS_POS   = 2'd3
    } flag_state_e;

endpackage

// File: rtl/sign_classifier.sv
module sign_classifier
    import sign_flag_pkg::*;
#(
    parameter int OP_W  = 32,
    parameter int SEG_W = 8
) (
    input  logic [OP_W-1:0] value,
    output op_class_e       op_class
);

    localparam int LOW_W = OP_W - 1;
    localparam int NSEG  = (LOW_W + SEG_W - 1) / SEG_W;
    localparam int PAD_W = NSEG * SEG_W;

    logic [PAD_W-1:0] low_padded;
    logic [NSEG-1:0]  seg_any;
    logic             low_any;

    always_comb begin
        low_padded             = '0;
        low_padded[LOW_W-1:0]  = value[LOW_W-1:0];
    end

    // Segmented OR tree over the magnitude bits.
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        assign seg_any[g] = |low_padded[g*SEG_W +: SEG_W];
    end

    assign low_any = |seg_any;

    always_comb begin
        if (value[OP_W-1]) begin
            op_class = CLS_NEG;
        end else if (low_any) begin
            op_class = CLS_POS;
        end else begin
            op_class = CLS_ZERO;
        end
    end

endmodule

// File: rtl/strobe_tracker.sv
module strobe_tracker
    import sign_flag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stb,
    output logic rise
);

    stb_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SS_BLOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        rise    = 1'b0;
        unique case (state_q)
            SS_ARMED: begin
                if (stb) begin
                    state_d = SS_BLOCKED;
                    rise    = 1'b1;
                end
            end
            SS_BLOCKED: begin
                if (!stb) begin
                    state_d = SS_ARMED;
                end
            end
        endcase
    end

endmodule

// File: rtl/flag_machine.sv
module flag_machine
    import sign_flag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  op_class_e op_class,
    output logic      n_out,
    output logic      z_out,
    output logic      p_out
);

    flag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (load) begin
            unique case (op_class)
                CLS_NEG:  state_d = FS_NEG;
                CLS_ZERO: state_d = FS_ZERO;
                CLS_POS:  state_d = FS_POS;
                default:  state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        n_out = 1'b0;
        z_out = 1'b0;
        p_out = 1'b0;
        unique case (state_q)
            FS_CLEAR: ;
            FS_NEG:   n_out = 1'b1;
            FS_ZERO:  z_out = 1'b1;
            FS_POS:   p_out = 1'b1;
        endcase
    end

endmodule

// File: rtl/sign_flag_reg.sv
module sign_flag_reg
    import sign_flag_pkg::*;
#(
    parameter int OP_W  = 32,
    parameter int SEG_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] operand,
    input  logic            load_stb,
    output logic            flag_n,
    output logic            flag_z,
    output logic            flag_p
);

    op_class_e cls;
    logic      rise;

    sign_classifier #(
        .OP_W  (OP_W),
        .SEG_W (SEG_W)
    ) u_cls (
        .value    (operand),
        .op_class (cls)
    );

    strobe_tracker u_stb (
        .clk  (clk),
        .rst  (rst),
        .stb  (load_stb),
        .rise (rise)
    );

    flag_machine u_flags (
        .clk      (clk),
        .rst      (rst),
        .load     (rise),
        .op_class (cls),
        .n_out    (flag_n),
        .z_out    (flag_z),
        .p_out    (flag_p)
    );

endmodule

// File: rtl/sign_flag_reg_chk.sv
module sign_flag_reg_chk #(
    parameter int OP_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [OP_W-1:0] operand,
    input logic            load_stb,
    input logic            flag_n,
    input logic            flag_z,
    input logic            flag_p
);

    // Independent record of the last strobe sample; high after reset (R8).
    logic seen_high;
    logic accept;
    logic loaded;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_high <= 1'b1;
            loaded    <= 1'b0;
        end else begin
            seen_high <= load_stb;
            if (accept) loaded <= 1'b1;
        end
    end

    assign accept = load_stb && !seen_high;

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!flag_n && !flag_z && !flag_p));

    a_r2_neg_load: assert property (@(posedge clk) disable iff (rst)
        (accept && operand[OP_W-1]) |=> (flag_n && !flag_z && !flag_p));

    a_r3_zero_load: assert property (@(posedge clk) disable iff (rst)
        (accept && operand == '0) |=> (!flag_n && flag_z && !flag_p));

    a_r4_pos_load: assert property (@(posedge clk) disable iff (rst)
        (accept && !operand[OP_W-1] && operand != '0) |=> (!flag_n && !flag_z && flag_p));

    a_r5_one_hot: assert property (@(posedge clk) disable iff (rst)
        loaded |-> $onehot({flag_n, flag_z, flag_p}));

    a_r5_never_multi: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flag_n, flag_z, flag_p}));

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable({flag_n, flag_z, flag_p}));

    a_r7_held_strobe: assert property (@(posedge clk) disable iff (rst)
        (load_stb && seen_high) |=> $stable({flag_n, flag_z, flag_p}));

endmodule

bind sign_flag_reg sign_flag_reg_chk #(.OP_W(OP_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .operand  (operand),
    .load_stb (load_stb),
    .flag_n   (flag_n),
    .flag_z   (flag_z),
    .flag_p   (flag_p)
);

// File: tb/sign_flag_reg_test.sv
`timescale 1ns/1ps
module sign_flag_reg_test;

    typedef struct {
        logic [2:0] nzp;
        logic       after_load;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] operand = '0;
    logic        load_stb = 1'b0;
    logic        flag_n, flag_z, flag_p;

    int checks = 0;
    int fails  = 0;
    exp_t sb[$];

    // Bench model of the requirements.
    logic [2:0] m_nzp   = 3'b000;
    logic       m_high  = 1'b1;
    logic       m_load  = 1'b0;

    always #2.5 clk = ~clk;

    sign_flag_reg uut (
        .clk      (clk),
        .rst      (rst),
        .operand  (operand),
        .load_stb (load_stb),
        .flag_n   (flag_n),
        .flag_z   (flag_z),
        .flag_p   (flag_p)
    );

    // Driver: apply one stimulus on the falling edge and queue the result
    // due after the following rising edge.
    task automatic step(input logic r, input logic [31:0] op, input logic s,
                        input string tag_override);
        exp_t e;
        string tag;
        @(negedge clk);
        rst      = r;
        operand  = op;
        load_stb = s;
        if (r) begin
            m_nzp  = 3'b000;
            m_high = 1'b1;
            m_load = 1'b0;
            tag    = "R1";
        end else if (s && !m_high) begin
            m_load = 1'b1;
            if (op[31])          begin m_nzp = 3'b100; tag = "R2"; end
            else if (op == 0)    begin m_nzp = 3'b010; tag = "R3"; end
            else                 begin m_nzp = 3'b001; tag = "R4"; end
            m_high = 1'b1;
        end else begin
            tag    = s ? "R7" : "R6";
            m_high = s;
        end
        if (tag_override != "") tag = tag_override;
        e.nzp        = m_nzp;
        e.after_load = m_load;
        e.tag        = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            logic [2:0] act;
            e   = sb.pop_front();
            act = {flag_n, flag_z, flag_p};
            checks++;
            if (act !== e.nzp) begin
                fails++;
                $display("FAIL %s: nzp actual %b expected %b", e.tag, act, e.nzp);
            end
            if (e.after_load) begin
                checks++;
                if ($countones(act) != 1) begin
                    fails++;
                    $display("FAIL R5: nzp actual %b expected one-hot", act);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        // R1 reset state
        step(1, 32'h8000_0000, 0, "R1");
        step(1, 32'h0000_0005, 1, "R1");
        // R8: strobe already high when reset is released
        step(0, 32'h8000_0000, 1, "R8");
        step(0, 32'h8000_0000, 1, "R8");
        step(0, 32'h8000_0000, 0, "R8");
        // R2 negative capture
        step(0, 32'hFFFF_FFFF, 1, "R2");
        // R7 held high with changing operand
        step(0, 32'h0000_0000, 1, "R7");
        step(0, 32'h0000_1234, 1, "R7");
        // R6 low strobe, operand moving
        step(0, 32'h0000_0000, 0, "R6");
        step(0, 32'h7FFF_FFFF, 0, "R6");
        // R3 zero capture
        step(0, 32'h0000_0000, 1, "R3");
        step(0, 32'h8000_0000, 0, "R6");
        // R4 smallest positive
        step(0, 32'h0000_0001, 1, "R4");
        step(0, 32'h8000_0001, 0, "R6");
        // R4 largest positive
        step(0, 32'h7FFF_FFFF, 1, "R4");
        step(0, 32'h7FFF_FFFF, 0, "");
        // R2 most negative
        step(0, 32'h8000_0000, 1, "R2");
        step(0, 32'h8000_0000, 0, "");
        // R4 high magnitude bit only
        step(0, 32'h4000_0000, 1, "R4");
        step(0, 32'h4000_0000, 0, "");
        // R3 back to zero, then R1 reset mid-run
        step(0, 32'h0000_0000, 1, "R3");
        step(1, 32'h0000_0000, 0, "R1");
        step(0, 32'h0000_00FF, 0, "R1");
        step(0, 32'h0000_00FF, 1, "R4");
        // alternating strobe every cycle
        for (int i = 0; i < 8; i++) begin
            step(0, (i % 3 == 0) ? 32'hF000_0000 : ((i % 3 == 1) ? 32'h0 : 32'h10),
                 i[0] ? 1'b0 : 1'b1, "");
        end
        step(0, 32'h0, 0, "");
        step(0, 32'h0, 0, "");
        wait (sb.size() == 0);
        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule